// File: doc/BRIEF.md
# Parallel-Track Read Deskew and Transfer Strobe

This block gathers the bits of one character that arrive on several parallel tape tracks at slightly different times. It then hands them on together as a single aligned data word. Each track delivers a one-cycle pulse when it detects a flux peak. The earliest pulse of a character starts a skew window. The window is timed by a small counter that runs on the fast clock, which is 32 times the character rate. Every track that pulses while the window is open has its bit held in a storage flop.

When the counter carries, the window closes. On the next cycle a one-cycle transfer strobe copies all stored bits into the output word at the same instant. The cycle after that, the storage flops are cleared. A test-mode level preloads the counter so the window is shorter. A pulse that arrives after the window has closed is a skew fault. If it arrives in the cycle just after closure, the window reopens from a fault preload, which extends it. If it arrives during the strobe, the bit is dropped. In both cases a sticky skew error is raised. The data word reaches the outputs only while the output enable is high.

Top module: `track_deskew`

## Requirements
- R1: While reset is held and just after it is released, `data_out`, `xfer_strobe` and `skew_err` are all 0.
- R2: With `test_mode` low, the first pulse of a character sets the counter to 0. A channel that pulses in the same cycle as that first pulse, or in any of the 16 following cycles, is captured. `xfer_strobe` rises 17 cycles after the first pulse.
- R3: With `test_mode` high when the first pulse arrives, the counter is set to 11. The window then covers the 5 following cycles, and `xfer_strobe` rises 6 cycles after the first pulse.
- R4: `xfer_strobe` is high for exactly one cycle per character. The captured bits of all channels appear on the output word in that same cycle, with bit i belonging to channel i.
- R5: A pulse in the cycle right after the window closes sets `skew_err`. It reopens the window with the counter at 4, so 12 more cycles are captured, and it is itself captured. The strobe then rises 13 cycles after that pulse.
- R6: A pulse in the cycle in which `xfer_strobe` is high sets `skew_err`, and its bit is not added to the word.
- R7: Storage is cleared after each strobe, so the next word holds only the channels that pulsed for that character.
- R8: While `out_en` is low, `data_out` is all zeros. The word is kept and shows again when `out_en` returns high.
- R9: `skew_err` stays set until `err_clr` is pulsed high. It then reads 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 32x character rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_pulse | input | N_CH | One-cycle peak pulse per channel |
| test_mode | input | 1 | Shortens the skew window when high at window start |
| out_en | input | 1 | Output enable for the data word |
| err_clr | input | 1 | Synchronous clear for the sticky skew error |
| data_out | output | N_CH | Deskewed character, zero while disabled |
| xfer_strobe | output | 1 | One-cycle transfer strobe |
| skew_err | output | 1 | Sticky skew fault flag |

## Verification
The bench builds the block with its default values: seven channels, a 4-bit counter, and window presets of 11 for test mode and 4 for a fault. These values give windows of 16, 5 and 12 cycles, short enough that every window edge can be hit in a few dozen cycles. Each case then runs in full: the last cycle inside the window, the first cycle after closure that reopens it, and a pulse that lands in the strobe cycle. Randomly placed channel pulses inside both normal and test windows exercise capture and clearing between characters.

// File: rtl/track_deskew_pkg.sv
package track_deskew_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPEN = 2'd1,
        PH_SHUT = 2'd2,
        PH_XFER = 2'd3
    } phase_e;
endpackage

// File: rtl/track_deskew_window.sv
module track_deskew_window
    import track_deskew_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int TEST_PRESET = 11,
    parameter int ERR_PRESET  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_pulse,
    input  logic test_mode,
    input  logic err_clr,
    output logic cap_en,
    output logic load,
    output logic xfer,
    output logic skew_err
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] TEST_V  = CNT_W'(TEST_PRESET);
    localparam logic [CNT_W-1:0] ERR_V   = CNT_W'(ERR_PRESET);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } win_t;

    win_t win_d, win_q;
    logic late;

    always_comb begin
        win_d = win_q;
        late  = 1'b0;
        case (win_q.phase)
            PH_IDLE: begin
                if (any_pulse) begin
                    win_d.phase = PH_OPEN;
                    win_d.cnt   = test_mode ? TEST_V : '0;
                end
            end
            PH_OPEN: begin
                win_d.cnt = win_q.cnt + 1'b1;
                if (win_q.cnt == CNT_TOP) win_d.phase = PH_SHUT;
            end
            PH_SHUT: begin
                if (any_pulse) begin
                    late        = 1'b1;
                    win_d.phase = PH_OPEN;
                    win_d.cnt   = ERR_V;
                end else begin
                    win_d.phase = PH_XFER;
                end
            end
            default: begin
                late        = any_pulse;
                win_d.phase = PH_IDLE;
            end
        endcase
        win_d.err = (win_q.err & ~err_clr) | late;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '{phase: PH_IDLE, cnt: '0, err: 1'b0};
        else        win_q <= win_d;
    end

    assign cap_en   = (win_q.phase != PH_XFER);
    assign load     = (win_q.phase == PH_SHUT) && !any_pulse;
    assign xfer     = (win_q.phase == PH_XFER);
    assign skew_err = win_q.err;

    p_test_preset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q.phase == PH_IDLE && any_pulse && test_mode)
        |=> (win_q.phase == PH_OPEN && win_q.cnt == TEST_V));
    p_reopen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q.phase == PH_SHUT && any_pulse)
        |=> (skew_err && win_q.phase == PH_OPEN && win_q.cnt == ERR_V));
    p_drop_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && any_pulse) |=> skew_err);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (skew_err && !err_clr) |=> skew_err);
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !xfer);
endmodule

// File: rtl/track_deskew_capture.sv
module track_deskew_capture #(
    parameter int N_CH = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pulse,
    input  logic            cap_en,
    input  logic            load,
    input  logic            clear,
    output logic [N_CH-1:0] word
);
    typedef struct packed {
        logic [N_CH-1:0] store;
        logic [N_CH-1:0] word;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [N_CH-1:0] store_nx, word_nx;

    for (genvar i = 0; i < N_CH; i++) begin : g_bit
        assign store_nx[i] = clear ? 1'b0 : (cap_q.store[i] | (cap_en & pulse[i]));
        assign word_nx[i]  = load ? cap_q.store[i] : cap_q.word[i];
    end

    always_comb begin
        cap_d       = cap_q;
        cap_d.store = store_nx;
        cap_d.word  = word_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign word = cap_q.word;

    p_load_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (word != '0));
endmodule

// File: rtl/track_deskew.sv
module track_deskew #(
    parameter int N_CH        = 7,
    parameter int CNT_W       = 4,
    parameter int TEST_PRESET = 11,
    parameter int ERR_PRESET  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] chan_pulse,
    input  logic            test_mode,
    input  logic            out_en,
    input  logic            err_clr,
    output logic [N_CH-1:0] data_out,
    output logic            xfer_strobe,
    output logic            skew_err
);
    logic any_pulse, cap_en, load, xfer;
    logic [N_CH-1:0] word;

    assign any_pulse = |chan_pulse;

    track_deskew_window #(
        .CNT_W(CNT_W), .TEST_PRESET(TEST_PRESET), .ERR_PRESET(ERR_PRESET)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .any_pulse(any_pulse), .test_mode(test_mode),
        .err_clr(err_clr), .cap_en(cap_en), .load(load), .xfer(xfer),
        .skew_err(skew_err)
    );

    track_deskew_capture #(.N_CH(N_CH)) u_cap (
        .clk(clk), .rst_n(rst_n), .pulse(chan_pulse), .cap_en(cap_en),
        .load(load), .clear(xfer), .word(word)
    );

    assign data_out    = out_en ? word : '0;
    assign xfer_strobe = xfer;

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (data_out == '0));
    p_clear_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_strobe && !any_pulse) |=> !xfer_strobe);
endmodule

// File: tb/track_deskew_test.sv
module track_deskew_test;
    localparam int N = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] chan_pulse = '0;
    logic test_mode = 1'b0, out_en = 1'b1, err_clr = 1'b0;
    logic [N-1:0] data_out;
    logic xfer_strobe, skew_err;

    int checks = 0, fails = 0;
    int off [N];

    always #4 clk = ~clk;

    track_deskew #(.N_CH(N)) uut (
        .clk(clk), .rst_n(rst_n), .chan_pulse(chan_pulse), .test_mode(test_mode),
        .out_en(out_en), .err_clr(err_clr), .data_out(data_out),
        .xfer_strobe(xfer_strobe), .skew_err(skew_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // window last cycle index after first pulse: 16 normal, 5 in test mode
    function automatic int win_last(input bit tm);
        return tm ? 5 : 16;
    endfunction

    function automatic int exp_strobe(input bit tm, input int late);
        int w = win_last(tm);
        return (late == w + 1) ? (w + 1 + 13) : (w + 1);
    endfunction

    function automatic logic [N-1:0] exp_word(input int lim);
        logic [N-1:0] w = '0;
        for (int c = 0; c < N; c++) if (off[c] >= 0 && off[c] <= lim) w[c] = 1'b1;
        return w;
    endfunction

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic run_char(input bit tm, input logic [N-1:0] ew, input int es,
                            input bit ee, input string req);
        int sat = -1, nst = 0;
        logic [N-1:0] dat = '0;
        test_mode = tm;
        for (int k = 0; k < 45; k++) begin
            logic [N-1:0] p = '0;
            @(negedge clk);
            if (k > 0 && xfer_strobe) begin
                nst++;
                if (sat < 0) begin sat = k - 1; dat = data_out; end
            end
            for (int c = 0; c < N; c++) if (off[c] == k) p[c] = 1'b1;
            chan_pulse = p;
        end
        chk(sat == es, {req, " strobe cycle"}, sat, es);
        chk(nst == 1, "R4 strobe width", nst, 1);
        chk(dat == ew, {req, " word"}, int'(dat), int'(ew));
        chk(skew_err == ee, {req, " skew_err"}, int'(skew_err), int'(ee));
    endtask

    task automatic clr_off();
        for (int c = 0; c < N; c++) off[c] = -1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2468));
        clr_off();
        repeat (3) @(negedge clk);
        chk(data_out == '0 && !xfer_strobe && !skew_err, "R1 in reset", int'(data_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(data_out == '0 && !xfer_strobe && !skew_err, "R1 after reset", int'(data_out), 0);

        // R2: last capture cycle of a normal window
        clr_off(); off[0] = 0; off[1] = 16;
        run_char(1'b0, 7'b0000011, exp_strobe(1'b0, -1), 1'b0, "R2");
        // R3: short test window edge
        clr_off(); off[0] = 0; off[2] = 5;
        run_char(1'b1, 7'b0000101, exp_strobe(1'b1, -1), 1'b0, "R3");
        // R5: late pulse reopens window, normal and test mode
        clr_off(); off[0] = 0; off[3] = 17;
        run_char(1'b0, 7'b0001001, exp_strobe(1'b0, 17), 1'b1, "R5");
        clear_err();
        clr_off(); off[5] = 0; off[3] = 6;
        run_char(1'b1, 7'b0101000, exp_strobe(1'b1, 6), 1'b1, "R5 test");
        // R9: sticky until cleared
        repeat (5) @(negedge clk);
        chk(skew_err == 1'b1, "R9 sticky", int'(skew_err), 1);
        clear_err();
        chk(skew_err == 1'b0, "R9 cleared", int'(skew_err), 0);
        // R6: pulse during strobe is dropped but flagged
        clr_off(); off[0] = 0; off[4] = 18;
        run_char(1'b0, 7'b0000001, exp_strobe(1'b0, 18), 1'b1, "R6");
        clear_err();
        // R8: disabled output, then re-enabled
        out_en = 1'b0;
        clr_off(); off[6] = 0; off[1] = 3;
        run_char(1'b0, 7'b0000000, exp_strobe(1'b0, -1), 1'b0, "R8 disabled");
        @(negedge clk); out_en = 1'b1; #1;
        chk(data_out == 7'b1000010, "R8 word kept", int'(data_out), 7'h42);

        // R4 R7 random characters inside the window
        for (int t = 0; t < 40; t++) begin
            bit tm = 1'($urandom_range(0, 1));
            int c0 = $urandom_range(0, N - 1);
            clr_off();
            for (int c = 0; c < N; c++)
                if ($urandom_range(0, 1) == 1) off[c] = $urandom_range(0, win_last(tm));
            off[c0] = 0;
            run_char(tm, exp_word(win_last(tm)), exp_strobe(tm, -1), 1'b0, "R7 random");
        end
        finish_run();
    end
endmodule